// File: doc/BRIEF.md
# Slave-FIFO bulk writer

This block moves a byte stream from an on-chip producer into the slave FIFO of an external USB controller. Bytes arrive on a valid/ready handshake. Each accepted byte goes out on an 8-bit bus, together with an active-low write strobe, in the next clock cycle. Writes may run back to back, one byte per cycle.

The writer closes every packet itself. After a fixed number of bytes, one video row (482 bytes by default), it pulses an active-low packet-end strobe. It never uses a change of the controller's full flag to end a packet. The full flag is consulted only in the idle state. Once writing has begun, the flag is ignored until the block next returns to idle.

The writer returns to idle in two ways. It commits a row, or it steps away after a programmable number of bytes so that other endpoints can be polled. Both paths pass through a short fixed gap before idle. The FIFO select lines, the read strobe and the output-enable line are held at constant values.

Top module: `sfw_writer`

## Requirements
- R1: While reset is high and in the first cycle after it, `fifo_wr_n` and `fifo_pktend_n` are 1, `fifo_data` is 0 and `src_ready` is 0.
- R2: A byte accepted at a clock edge (`src_valid` and `src_ready` both high) appears on `fifo_data`, with `fifo_wr_n` low, in the cycle that follows. Bytes leave in acceptance order, at up to one per cycle.
- R3: In every cycle in which `fifo_wr_n` is high, `fifo_data` keeps the value it had in the cycle before.
- R4: After every ROW_LEN-th byte counted from reset, `fifo_pktend_n` is low for exactly one cycle. That cycle directly follows the write-strobe cycle of the row's last byte, and `fifo_wr_n` is high in it.
- R5: In the idle state, no byte is accepted while `ep_full` is high. When `ep_full` goes low with `src_valid` high, the first write strobe appears in the second cycle after the change.
- R6: While writing, `ep_full` has no effect. A row in progress continues at one byte per cycle.
- R7: When `poll_every` is nonzero, the writer leaves the write state after every `poll_every`-th byte counted since reset, the last commit or the last poll. It issues no packet-end, and its next write strobe comes GAP_CYCLES+2 cycles after the previous one. A commit path puts GAP_CYCLES+3 cycles between strobes. A `poll_every` of 0 disables polling.
- R8: When a commit and a poll fall due on the same byte, the commit is taken. The poll count restarts from zero at every commit.
- R9: The bytes on either side of a poll gap reach the bus unchanged and in order.
- R10: `fifo_rd_n` and `fifo_oe_n` are always 1, and `fifo_sel` always equals EP_SEL.
- R11: If `src_valid` drops during a row, the writer stays in the write state with `fifo_wr_n` high and resumes without losing or repeating a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_data | input | DATA_W | Producer byte |
| src_valid | input | 1 | Producer byte valid |
| src_ready | output | 1 | Byte accepted at this edge when valid |
| ep_full | input | 1 | Controller endpoint full flag, active high |
| poll_every | input | POLL_W | Bytes between poll exits, 0 = never |
| fifo_data | output | DATA_W | Data bus to the controller FIFO |
| fifo_wr_n | output | 1 | Write strobe, active low |
| fifo_pktend_n | output | 1 | Packet-end strobe, active low |
| fifo_rd_n | output | 1 | Read strobe, held at 1 |
| fifo_oe_n | output | 1 | FIFO output enable, held at 1 |
| fifo_sel | output | SEL_W | Endpoint select, held at EP_SEL |

## Verification
The bench is built on the fixed latencies of the design. A byte accepted at an edge shows its strobe one cycle later. Packet-end follows the last byte of a row by exactly one cycle. A release of the full flag in idle shows its first strobe two cycles later. The poll and commit paths put GAP_CYCLES+2 and GAP_CYCLES+3 cycles between strobes. A monitor samples the bus shortly after each falling clock edge and records the cycle index of every strobe. Each test compares the spacing of consecutive strobes with a value it derives from the row length and the poll period. It also compares the packet lengths and the byte order with the stream it fed in.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WRITE  = 2'd1,
    ST_COMMIT = 2'd2,
    ST_GAP    = 2'd3
  } sfw_state_e;
endpackage

// File: rtl/sfw_span_counter.sv
// Counts steps and reports the step that reaches the limit, then wraps.
// A limit of zero disables the wrap report.
module sfw_span_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt;
  logic [W:0]   nxt;

  assign nxt  = {1'b0, cnt} + (W+1)'(1);
  assign last = step && (limit != '0) && (nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step)    cnt <= last ? '0 : nxt[W-1:0];
  end

  // R7: with an unchanged limit the count never reaches it
  assert_count_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    ((limit != '0) && $stable(limit) && ($past(cnt) < limit)) |-> (cnt < limit));
endmodule

// File: rtl/sfw_gap_timer.sv
// Counts the cycles spent in the gap state and signals the last one.
module sfw_gap_timer #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int GW = (GAP < 2) ? 1 : $clog2(GAP + 1);
  logic [GW-1:0] cnt;

  assign done = run && (cnt == GW'(GAP - 1));

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (run && !done) cnt <= cnt + GW'(1);
    else                   cnt <= '0;
  end

  // R7: the gap never lasts longer than GAP cycles
  assert_gap_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt < GW'(GAP));
endmodule

// File: rtl/sfw_bus_regs.sv
// Output register stage for the FIFO data bus and both strobes.
module sfw_bus_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          commit,
  output logic [DW-1:0] dout,
  output logic          wr_n,
  output logic          pktend_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      wr_n     <= 1'b1;
      pktend_n <= 1'b1;
    end else begin
      if (load) dout <= din;
      wr_n     <= !load;
      pktend_n <= !commit;
    end
  end

  // R3: the bus holds its value while no write is strobed
  assert_bus_hold_R3: assert property (@(posedge clk) disable iff (rst)
    wr_n |-> $stable(dout));
  // R4: packet-end is a single-cycle pulse
  assert_pktend_single_R4: assert property (@(posedge clk) disable iff (rst)
    !pktend_n |=> pktend_n);
endmodule

// File: rtl/sfw_writer.sv
module sfw_writer
  import sfw_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ROW_LEN    = 482,
  parameter int POLL_W     = 16,
  parameter int GAP_CYCLES = 2,
  parameter int SEL_W      = 2,
  parameter logic [SEL_W-1:0] EP_SEL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic              ep_full,
  input  logic [POLL_W-1:0] poll_every,
  output logic [DATA_W-1:0] fifo_data,
  output logic              fifo_wr_n,
  output logic              fifo_pktend_n,
  output logic              fifo_rd_n,
  output logic              fifo_oe_n,
  output logic [SEL_W-1:0]  fifo_sel
);
  localparam int ROW_W = $clog2(ROW_LEN + 1);

  sfw_state_e state, state_nxt;
  logic fire, row_last, poll_last, gap_done;

  assign fire      = (state == ST_WRITE) && src_valid;
  assign src_ready = (state == ST_WRITE);

  sfw_span_counter #(.W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .step(fire), .clear(1'b0),
    .limit(ROW_W'(ROW_LEN)), .last(row_last)
  );

  sfw_span_counter #(.W(POLL_W)) u_poll (
    .clk(clk), .rst(rst), .step(fire), .clear(fire && row_last),
    .limit(poll_every), .last(poll_last)
  );

  sfw_gap_timer #(.GAP(GAP_CYCLES)) u_gap (
    .clk(clk), .rst(rst), .run(state == ST_GAP), .done(gap_done)
  );

  sfw_bus_regs #(.DW(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .load(fire), .din(src_data),
    .commit(state == ST_COMMIT), .dout(fifo_data),
    .wr_n(fifo_wr_n), .pktend_n(fifo_pktend_n)
  );

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:   if (!ep_full && src_valid) state_nxt = ST_WRITE;
      ST_WRITE:  if (fire) begin
                   if (row_last)       state_nxt = ST_COMMIT;
                   else if (poll_last) state_nxt = ST_GAP;
                 end
      ST_COMMIT: state_nxt = ST_GAP;
      ST_GAP:    if (gap_done) state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      fifo_rd_n <= 1'b1;
      fifo_oe_n <= 1'b1;
      fifo_sel  <= EP_SEL;
    end else begin
      state     <= state_nxt;
      fifo_rd_n <= 1'b1;
      fifo_oe_n <= 1'b1;
      fifo_sel  <= EP_SEL;
    end
  end

  // R2: an accepted byte is strobed onto the bus in the next cycle
  assert_accept_strobes_R2: assert property (@(posedge clk) disable iff (rst)
    (src_valid && src_ready) |=> (!fifo_wr_n && fifo_data == $past(src_data)));
  // R4: packet-end follows the row's last strobe and never overlaps a write
  assert_pktend_after_byte_R4: assert property (@(posedge clk) disable iff (rst)
    !fifo_pktend_n |-> (fifo_wr_n && $past(!fifo_wr_n)));
  // R5: a full endpoint keeps the idle state
  assert_idle_respects_full_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && ep_full) |=> (state == ST_IDLE));
  // R11: no strobe without an accepted byte
  assert_no_empty_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    (!src_valid || !src_ready) |=> fifo_wr_n);
endmodule

// File: tb/sfw_writer_bench.sv
module sfw_writer_bench;
  localparam int ROW = 20;
  localparam int GAP = 2;
  localparam int PW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] src_data = '0;
  logic src_valid = 1'b0;
  logic src_ready;
  logic ep_full = 1'b0;
  logic [PW-1:0] poll_every = '0;
  logic [7:0] fifo_data;
  logic fifo_wr_n, fifo_pktend_n, fifo_rd_n, fifo_oe_n;
  logic [1:0] fifo_sel;

  always #2.5 clk = ~clk;

  sfw_writer #(.DATA_W(8), .ROW_LEN(ROW), .POLL_W(PW), .GAP_CYCLES(GAP),
               .SEL_W(2), .EP_SEL(2'b10)) u_sfw_writer (
    .clk(clk), .rst(rst), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .ep_full(ep_full), .poll_every(poll_every),
    .fifo_data(fifo_data), .fifo_wr_n(fifo_wr_n), .fifo_pktend_n(fifo_pktend_n),
    .fifo_rd_n(fifo_rd_n), .fifo_oe_n(fifo_oe_n), .fifo_sel(fifo_sel)
  );

  int n_chk = 0, n_fail = 0;
  int total = 0, sent = 0, cyc = 0;
  bit stall = 0, stall_ph = 0;
  logic [7:0] got[$];
  int wcyc[$];
  int pkts[$];
  int pkt_bytes = 0, hold_err = 0, pk_err = 0, const_err = 0;
  logic [7:0] prev_data = '0;
  logic prev_wr_n = 1'b1;

  function automatic logic [7:0] val(int k);
    return 8'((k * 7 + 3) & 255);
  endfunction

  // expected strobe spacing before byte i, from R4, R7 and R8
  function automatic int exp_gap(int i, int poll);
    int k;
    if (i % ROW == 0) return GAP + 3;
    k = i % ROW;
    if (poll != 0 && (k % poll) == 0) return GAP + 2;
    return 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // producer model
  initial forever begin
    @(negedge clk);
    stall_ph = ~stall_ph;
    if (!rst && sent < total && !(stall && stall_ph)) begin
      src_valid = 1'b1;
      src_data  = val(sent);
    end else begin
      src_valid = 1'b0;
    end
    #1;
    if (src_valid && src_ready) sent++;
  end

  // external FIFO model
  initial forever begin
    @(negedge clk);
    #2;
    cyc++;
    if (!rst) begin
      if (!fifo_wr_n) begin
        got.push_back(fifo_data);
        wcyc.push_back(cyc);
        pkt_bytes++;
      end
      if (!fifo_pktend_n) begin
        pkts.push_back(pkt_bytes);
        pkt_bytes = 0;
        if (!fifo_wr_n || prev_wr_n) pk_err++;
      end
      if (fifo_wr_n && fifo_data != prev_data) hold_err++;
      if (fifo_rd_n !== 1'b1 || fifo_oe_n !== 1'b1 || fifo_sel !== 2'b10) const_err++;
    end
    prev_data = fifo_data;
    prev_wr_n = fifo_wr_n;
  end

  task automatic do_reset();
    total = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    sent = 0;
    got.delete(); wcyc.delete(); pkts.delete();
    pkt_bytes = 0;
    rst = 1'b0;
  endtask

  task automatic run_to_end();
    wait (sent == total);
    repeat (12) @(negedge clk);
  endtask

  function automatic int data_mism();
    int m = 0;
    foreach (got[i]) if (got[i] != val(i)) m++;
    return m;
  endfunction

  function automatic int gap_mism(int poll);
    int m = 0;
    for (int i = 1; i < wcyc.size(); i++)
      if (wcyc[i] - wcyc[i-1] != exp_gap(i, poll)) m++;
    return m;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 wr_n in reset", fifo_wr_n, 1);
    chk("R1 pktend_n in reset", fifo_pktend_n, 1);
    chk("R1 data in reset", fifo_data, 0);
    chk("R1 ready in reset", src_ready, 0);
    chk("R10 sel in reset", fifo_sel, 2);
    rst = 1'b0;
    @(negedge clk); #2;
    chk("R1 wr_n after reset", fifo_wr_n, 1);
    chk("R1 ready after reset", src_ready, 0);
  endtask

  task automatic t_stream();
    do_reset();
    poll_every = 0; stall = 0;
    total = 2 * ROW + 5;
    run_to_end();
    chk("R2 byte count", got.size(), 2 * ROW + 5);
    chk("R2 byte order", data_mism(), 0);
    chk("R2 strobe spacing", gap_mism(0), 0);
    chk("R4 packet count", pkts.size(), 2);
    if (pkts.size() == 2) begin
      chk("R4 first packet length", pkts[0], ROW);
      chk("R4 second packet length", pkts[1], ROW);
    end
    chk("R4 pktend placement", pk_err, 0);
    chk("R3 bus hold", hold_err, 0);
  endtask

  task automatic t_full_idle();
    do_reset();
    ep_full = 1'b1; poll_every = 0;
    total = 8;
    repeat (30) @(negedge clk);
    chk("R5 no write while full", got.size(), 0);
    ep_full = 1'b0;
    @(negedge clk); #2;
    chk("R5 no strobe one cycle after release", fifo_wr_n, 1);
    @(negedge clk); #2;
    chk("R5 strobe two cycles after release", fifo_wr_n, 0);
    run_to_end();
    chk("R5 bytes after release", data_mism() + got.size(), 8);
  endtask

  task automatic t_full_write();
    do_reset();
    poll_every = 0;
    total = 12;
    wait (got.size() >= 3);
    ep_full = 1'b1;
    run_to_end();
    ep_full = 1'b0;
    chk("R6 bytes written under full", got.size(), 12);
    chk("R6 back-to-back under full", gap_mism(0), 0);
    chk("R6 byte order", data_mism(), 0);
  endtask

  task automatic t_poll();
    do_reset();
    poll_every = 5;
    total = 17;
    run_to_end();
    chk("R7 poll spacing", gap_mism(5), 0);
    chk("R7 no pktend on poll", pkts.size(), 0);
    chk("R9 bytes around poll gaps", data_mism(), 0);
    chk("R9 byte count", got.size(), 17);
  endtask

  task automatic t_both();
    do_reset();
    poll_every = 5;
    total = 26;
    run_to_end();
    chk("R8 commit wins spacing", gap_mism(5), 0);
    chk("R8 one packet", pkts.size(), 1);
    do_reset();
    poll_every = 6;
    total = 28;
    run_to_end();
    chk("R8 poll restart after commit", gap_mism(6), 0);
    chk("R8 byte order", data_mism(), 0);
    poll_every = 0;
  endtask

  task automatic t_stall();
    do_reset();
    stall = 1;
    total = 30;
    run_to_end();
    stall = 0;
    chk("R11 byte count with stalls", got.size(), 30);
    chk("R11 byte order with stalls", data_mism(), 0);
    chk("R11 packet with stalls", pkts.size(), 1);
    chk("R10 constant lines", const_err, 0);
    chk("R3 bus hold overall", hold_err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_stream();
    t_full_idle();
    t_full_write();
    t_poll();
    t_both();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule